// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI and LO Result Registers

This block does integer multiply and divide for a 32-bit load/store core. It holds the two result registers, HI and LO, that the core reads back with its move-from instructions. The core places a function code and two operands on the inputs and pulses `start`. Multiply and divide run iteratively, one bit per cycle. While they run, `busy` is high and the unit ignores any further `start`. The move-to codes load HI or LO in a single cycle. They use the same write port that stores computed results.

Signed operations first convert both operands to their magnitudes, run the unsigned engine, and fix the sign of the result in the completion cycle. A divide whose divisor is zero is dropped as soon as it arrives. The core reads HI or LO through a combinational port. When a read is requested while an operation is in flight, the unit raises a stall request instead of handing out the old value.

The controller is a five-state machine:
- `ST_IDLE` accepts commands.
- `ST_MUL_RUN` and `ST_DIV_RUN` each take one iteration per cycle.
- `ST_MUL_DONE` and `ST_DIV_DONE` apply the sign fix and write HI/LO.

Transitions:
- `ST_IDLE` goes to `ST_MUL_RUN` on an accepted multiply code.
- `ST_IDLE` goes to `ST_DIV_RUN` on an accepted divide code with a nonzero divisor.
- Each run state goes to its done state once the iteration counter reaches its last step.
- Each done state returns to `ST_IDLE` unconditionally.
- Any other input leaves `ST_IDLE` where it is.

Top module: `muldiv_unit`

## Requirements
- R1: Function code 0x18 (signed multiply) forms the 64-bit two's-complement product of A and B. The upper half goes to HI and the lower half to LO.
- R2: Function code 0x19 (unsigned multiply) forms the 64-bit unsigned product of A and B, split the same way: upper half in HI, lower half in LO.
- R3: Function code 0x1A (signed divide) writes A/B to LO and the remainder to HI. The quotient truncates toward zero and a nonzero remainder has the sign of A.
- R4: Function code 0x1B (unsigned divide) writes the unsigned quotient A/B to LO and the unsigned remainder to HI.
- R5: A divide (0x1A or 0x1B) with B equal to zero leaves HI and LO unchanged and never raises `busy`.
- R6: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0, with no other effect.
- R7: Code 0x11 copies A into HI and code 0x13 copies A into LO. Each takes effect at the accepting clock edge, and `busy` stays low.
- R8: An accepted multiply or divide (nonzero divisor) holds `busy` high for exactly WIDTH+1 cycles after the accepting edge. HI and LO show the result in the cycle in which `busy` falls.
- R9: `start` is ignored while `busy` is high. `start` is also ignored with any code other than 0x11, 0x13 and 0x18 to 0x1B, including the move-from codes 0x10 and 0x12. HI and LO never change while an operation runs.
- R10: `mf_data` shows HI when `mf_hi` is 1 and LO when it is 0. `mf_stall` equals `mf_req` while `busy` is high and is 0 otherwise.
- R11: After reset, HI and LO are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, sampled in `ST_IDLE` |
| func | input | 6 | Function code of the command |
| opnd_a | input | WIDTH | First operand (dividend, multiplicand, move source) |
| opnd_b | input | WIDTH | Second operand (divisor, multiplier) |
| mf_req | input | 1 | Move-from read request |
| mf_hi | input | 1 | Read select: 1 = HI, 0 = LO |
| mf_data | output | WIDTH | Selected result register |
| mf_stall | output | 1 | Read must wait; an operation is in flight |
| busy | output | 1 | Iterative operation in progress |
| hi_out | output | WIDTH | Current HI contents |
| lo_out | output | WIDTH | Current LO contents |

## Verification
The bench builds the unit with WIDTH = 32, so that its 64-bit reference arithmetic lines up with the real operand and product sizes. This width brings the extreme operands within reach: the most negative value, all-ones, one and zero. It therefore covers the overflowing signed quotient, sign fixes on every sign combination, and the carry out of the top product bit. At this width every operation also takes the full 33-cycle busy window. That leaves room to inject commands and move-from reads in the middle of a run.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam logic [5:0] FN_MFHI  = 6'h10;
    localparam logic [5:0] FN_MTHI  = 6'h11;
    localparam logic [5:0] FN_MFLO  = 6'h12;
    localparam logic [5:0] FN_MTLO  = 6'h13;
    localparam logic [5:0] FN_MULT  = 6'h18;
    localparam logic [5:0] FN_MULTU = 6'h19;
    localparam logic [5:0] FN_DIV   = 6'h1A;
    localparam logic [5:0] FN_DIVU  = 6'h1B;

    typedef enum logic [2:0] {
        K_NONE,
        K_SET_HI,
        K_SET_LO,
        K_MUL,
        K_DIV
    } md_kind_e;

    typedef struct packed {
        md_kind_e kind;
        logic     signed_op;
    } md_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL_RUN,
        ST_DIV_RUN,
        ST_MUL_DONE,
        ST_DIV_DONE
    } md_state_e;

    function automatic md_cmd_t decode_fn(input logic [5:0] fn);
        md_cmd_t c;
        c.kind      = K_NONE;
        c.signed_op = 1'b0;
        case (fn)
            FN_MTHI:  c.kind = K_SET_HI;
            FN_MTLO:  c.kind = K_SET_LO;
            FN_MULT:  begin c.kind = K_MUL; c.signed_op = 1'b1; end
            FN_MULTU: c.kind = K_MUL;
            FN_DIV:   begin c.kind = K_DIV; c.signed_op = 1'b1; end
            FN_DIVU:  c.kind = K_DIV;
            default:  c.kind = K_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mul_core.sv
module mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic [2*W-1:0] prod_o
);
    logic [W-1:0] mcand_q;
    logic [W-1:0] upper_q;
    logic [W-1:0] lower_q;
    logic [W:0]   partial;

    // Add the multiplicand when the current multiplier bit is set, keeping the carry.
    always_comb begin
        partial = {1'b0, upper_q} + (lower_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            upper_q <= '0;
            lower_q <= '0;
        end else if (load) begin
            mcand_q <= mcand_i;
            upper_q <= '0;
            lower_q <= mplier_i;
        end else if (step) begin
            upper_q <= partial[W:1];
            lower_q <= {partial[0], lower_q[W-1:1]};
        end
    end

    assign prod_o = {upper_q, lower_q};

endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] dvs_q;
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W:0]   shifted;
    logic [W:0]   trial;

    // Restoring step: shift in the next dividend bit, try subtracting the divisor.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvs_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            dvs_q <= dvs_i;
            rem_q <= '0;
            quo_q <= dvd_i;
        end else if (step) begin
            if (!trial[W]) begin
                rem_q <= trial[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

    // R4: the partial remainder stays below a nonzero divisor at every step
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/hilo_regs.sv
module hilo_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hi_we,
    input  logic         lo_we,
    input  logic [W-1:0] hi_d,
    input  logic [W-1:0] lo_d,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_we) hi_q <= hi_d;
            if (lo_we) lo_q <= lo_d;
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [5:0]       func,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             mf_req,
    input  logic             mf_hi,
    output logic [WIDTH-1:0] mf_data,
    output logic             mf_stall,
    output logic             busy,
    output logic [WIDTH-1:0] hi_out,
    output logic [WIDTH-1:0] lo_out
);
    localparam int              CW   = $clog2(WIDTH + 1);
    localparam logic [CW-1:0]   ITER = CW'(WIDTH);
    localparam logic [CW-1:0]   LAST = CW'(1);

    md_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          flip_main_q;
    logic          flip_rem_q;

    md_cmd_t            cmd;
    logic               accept;
    logic               neg_a, neg_b;
    logic [WIDTH-1:0]   mag_a, mag_b;
    logic               div_zero;

    logic               mul_load, mul_step, div_load, div_step;
    logic [2*WIDTH-1:0] prod;
    logic [2*WIDTH-1:0] prod_fix;
    logic [WIDTH-1:0]   quo, rem;
    logic               hi_we, lo_we;
    logic [WIDTH-1:0]   hi_d, lo_d;

    // Command decode and operand magnitudes
    always_comb begin
        cmd      = decode_fn(func);
        accept   = start && (state_q == ST_IDLE);
        neg_a    = cmd.signed_op && opnd_a[WIDTH-1];
        neg_b    = cmd.signed_op && opnd_b[WIDTH-1];
        mag_a    = neg_a ? (~opnd_a + 1'b1) : opnd_a;
        mag_b    = neg_b ? (~opnd_b + 1'b1) : opnd_b;
        div_zero = (opnd_b == '0);
    end

    // State register, iteration counter and sign-fix flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            flip_main_q <= 1'b0;
            flip_rem_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q       <= ITER;
                flip_main_q <= neg_a ^ neg_b;
                flip_rem_q  <= neg_a;
            end else if (state_q == ST_MUL_RUN || state_q == ST_DIV_RUN) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && cmd.kind == K_MUL)
                    state_d = ST_MUL_RUN;
                else if (accept && cmd.kind == K_DIV && !div_zero)
                    state_d = ST_DIV_RUN;
            end
            ST_MUL_RUN:  if (cnt_q == LAST) state_d = ST_MUL_DONE;
            ST_DIV_RUN:  if (cnt_q == LAST) state_d = ST_DIV_DONE;
            ST_MUL_DONE: state_d = ST_IDLE;
            ST_DIV_DONE: state_d = ST_IDLE;
        endcase
    end

    // Per-state controls and the shared HI/LO write port
    always_comb begin
        mul_load = 1'b0;
        mul_step = 1'b0;
        div_load = 1'b0;
        div_step = 1'b0;
        hi_we    = 1'b0;
        lo_we    = 1'b0;
        hi_d     = opnd_a;
        lo_d     = opnd_a;
        prod_fix = flip_main_q ? (~prod + 1'b1) : prod;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    case (cmd.kind)
                        K_SET_HI: hi_we    = 1'b1;
                        K_SET_LO: lo_we    = 1'b1;
                        K_MUL:    mul_load = 1'b1;
                        K_DIV:    div_load = !div_zero;
                        default:  ;
                    endcase
                end
            end
            ST_MUL_RUN: mul_step = 1'b1;
            ST_DIV_RUN: div_step = 1'b1;
            ST_MUL_DONE: begin
                hi_we = 1'b1;
                lo_we = 1'b1;
                hi_d  = prod_fix[2*WIDTH-1:WIDTH];
                lo_d  = prod_fix[WIDTH-1:0];
            end
            ST_DIV_DONE: begin
                hi_we = 1'b1;
                lo_we = 1'b1;
                hi_d  = flip_rem_q  ? (~rem + 1'b1) : rem;
                lo_d  = flip_main_q ? (~quo + 1'b1) : quo;
            end
        endcase
    end

    mul_core #(.W(WIDTH)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mul_load),
        .step     (mul_step),
        .mcand_i  (mag_a),
        .mplier_i (mag_b),
        .prod_o   (prod)
    );

    div_core #(.W(WIDTH)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (div_load),
        .step  (div_step),
        .dvd_i (mag_a),
        .dvs_i (mag_b),
        .quo_o (quo),
        .rem_o (rem)
    );

    hilo_regs #(.W(WIDTH)) u_hilo (
        .clk   (clk),
        .rst_n (rst_n),
        .hi_we (hi_we),
        .lo_we (lo_we),
        .hi_d  (hi_d),
        .lo_d  (lo_d),
        .hi_q  (hi_out),
        .lo_q  (lo_out)
    );

    assign busy     = (state_q != ST_IDLE);
    assign mf_stall = mf_req && busy;
    assign mf_data  = mf_hi ? hi_out : lo_out;

    // R7: a move-to-LO lands on the following cycle
    p_set_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd.kind == K_SET_LO) |=> (lo_out == $past(opnd_a)));

    // R5: a zero divisor leaves the result registers and busy untouched
    p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd.kind == K_DIV && div_zero) |=>
            (!busy && $stable(hi_out) && $stable(lo_out)));

    // R9: the result registers hold while an iteration runs
    p_quiet_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL_RUN || state_q == ST_DIV_RUN) |=>
            ($stable(hi_out) && $stable(lo_out)));

    // R8: completion releases the unit on the next cycle
    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL_DONE || state_q == ST_DIV_DONE) |=> !busy);

endmodule

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [5:0]    func = 6'h0;
    logic [W-1:0]  opnd_a = '0;
    logic [W-1:0]  opnd_b = '0;
    logic          mf_req = 1'b0;
    logic          mf_hi = 1'b0;
    logic [W-1:0]  mf_data;
    logic          mf_stall;
    logic          busy;
    logic [W-1:0]  hi_out;
    logic [W-1:0]  lo_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    muldiv_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .mf_req(mf_req), .mf_hi(mf_hi),
        .mf_data(mf_data), .mf_stall(mf_stall), .busy(busy),
        .hi_out(hi_out), .lo_out(lo_out)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference arithmetic, returns {hi, lo}
    function automatic bit [63:0] ref_calc(input bit [5:0] fn, input bit [31:0] a, input bit [31:0] b);
        bit [63:0] r;
        int q;
        int m;
        longint p;
        r = '0;
        case (fn)
            6'h18: begin p = longint'($signed(a)) * longint'($signed(b)); r = p; end
            6'h19: r = {32'b0, a} * {32'b0, b};
            6'h1A: begin
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) r = {32'h0, 32'h8000_0000};
                else begin
                    q = $signed(a) / $signed(b);
                    m = $signed(a) % $signed(b);
                    r = {m, q};
                end
            end
            6'h1B: r = {a % b, a / b};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input bit [5:0] fn, input bit [31:0] a, input bit [31:0] b);
        case (fn)
            6'h18: return "R1";
            6'h19: return "R2";
            6'h1A: return (b == 0) ? "R5" : ((a == 32'h8000_0000 && b == 32'hFFFF_FFFF) ? "R6" : "R3");
            6'h1B: return (b == 0) ? "R5" : "R4";
            default: return "R7";
        endcase
    endfunction

    // Behavioural reference model, advanced on every clock
    bit [31:0] m_hi, m_lo, p_hi, p_lo;
    bit        m_busy;
    int        m_cnt;
    string     cur_tag = "R11";
    string     p_tag = "R11";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hi <= 0; m_lo <= 0; m_busy <= 0; m_cnt <= 0;
        end else if (m_busy) begin
            if (m_cnt == 1) begin
                m_hi <= p_hi; m_lo <= p_lo; m_busy <= 0; cur_tag <= p_tag;
            end
            m_cnt <= m_cnt - 1;
        end else if (start) begin
            case (func)
                6'h11: begin m_hi <= opnd_a; cur_tag <= "R7"; end
                6'h13: begin m_lo <= opnd_a; cur_tag <= "R7"; end
                6'h18, 6'h19, 6'h1A, 6'h1B: begin
                    if ((func == 6'h1A || func == 6'h1B) && opnd_b == 0) begin
                        cur_tag <= "R5";
                    end else begin
                        {p_hi, p_lo} <= ref_calc(func, opnd_a, opnd_b);
                        p_tag  <= tag_of(func, opnd_a, opnd_b);
                        m_busy <= 1;
                        m_cnt  <= W + 1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === m_busy, "R8 busy", {63'b0, busy}, {63'b0, m_busy});
            chk(hi_out === m_hi, {cur_tag, " hi"}, {32'b0, hi_out}, {32'b0, m_hi});
            chk(lo_out === m_lo, {cur_tag, " lo"}, {32'b0, lo_out}, {32'b0, m_lo});
            chk(mf_stall === (mf_req && m_busy), "R10 stall", {63'b0, mf_stall}, {63'b0, mf_req && m_busy});
            chk(mf_data === (mf_hi ? m_hi : m_lo), "R10 data", {32'b0, mf_data}, {32'b0, (mf_hi ? m_hi : m_lo)});
        end
    end

    // Issue one command, then count the cycles busy stays high
    task automatic run_op(input bit [5:0] fn, input bit [31:0] a, input bit [31:0] b, input int exp_busy);
        int n;
        @(negedge clk);
        start = 1'b1; func = fn; opnd_a = a; opnd_b = b;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_busy, "R8 busy length", 64'(n), 64'(exp_busy));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam bit [31:0] CORNER [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0007};

    initial begin
        bit [31:0] hold_hi, hold_lo;
        void'($urandom(17));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(hi_out == 0 && lo_out == 0, "R11 reset regs", {hi_out, lo_out}, 64'h0);
        chk(busy == 1'b0, "R11 reset busy", {63'b0, busy}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: direct writes
        run_op(6'h11, 32'hA5A5_0001, 32'h0, 0);
        chk(hi_out == 32'hA5A5_0001, "R7 mthi", {32'b0, hi_out}, 64'hA5A5_0001);
        run_op(6'h13, 32'h1234_5678, 32'h0, 0);
        chk(lo_out == 32'h1234_5678, "R7 mtlo", {32'b0, lo_out}, 64'h1234_5678);

        // R5: zero divisor, both forms
        run_op(6'h1A, 32'h0000_0100, 32'h0, 0);
        chk(hi_out == 32'hA5A5_0001 && lo_out == 32'h1234_5678, "R5 div zero",
            {hi_out, lo_out}, {32'hA5A5_0001, 32'h1234_5678});
        run_op(6'h1B, 32'hFFFF_FFFF, 32'h0, 0);
        chk(hi_out == 32'hA5A5_0001 && lo_out == 32'h1234_5678, "R5 divu zero",
            {hi_out, lo_out}, {32'hA5A5_0001, 32'h1234_5678});

        // R6: overflowing signed quotient
        run_op(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, W + 1);
        chk(lo_out == 32'h8000_0000 && hi_out == 0, "R6 min div -1",
            {hi_out, lo_out}, {32'h0, 32'h8000_0000});

        // R3: signed divide sign cases
        run_op(6'h1A, 32'hFFFF_FFF9, 32'h0000_0002, W + 1);   // -7 / 2
        chk(lo_out == 32'hFFFF_FFFD && hi_out == 32'hFFFF_FFFF, "R3 -7/2",
            {hi_out, lo_out}, {32'hFFFF_FFFF, 32'hFFFF_FFFD});
        run_op(6'h1A, 32'h0000_0007, 32'hFFFF_FFFE, W + 1);   // 7 / -2
        chk(lo_out == 32'hFFFF_FFFD && hi_out == 32'h1, "R3 7/-2",
            {hi_out, lo_out}, {32'h1, 32'hFFFF_FFFD});

        // R1, R2: multiply corners
        run_op(6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, W + 1);
        chk(hi_out == 0 && lo_out == 1, "R1 -1*-1", {hi_out, lo_out}, 64'h1);
        run_op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, W + 1);
        chk(hi_out == 32'hFFFF_FFFE && lo_out == 1, "R2 max*max",
            {hi_out, lo_out}, {32'hFFFF_FFFE, 32'h1});
        run_op(6'h18, 32'h8000_0000, 32'h8000_0000, W + 1);
        chk(hi_out == 32'h4000_0000 && lo_out == 0, "R1 min*min",
            {hi_out, lo_out}, {32'h4000_0000, 32'h0});

        // R4: unsigned divide
        run_op(6'h1B, 32'hFFFF_FFFF, 32'h0000_0010, W + 1);
        chk(lo_out == 32'h0FFF_FFFF && hi_out == 32'hF, "R4 divu",
            {hi_out, lo_out}, {32'hF, 32'h0FFF_FFFF});

        // R9, R10: command and reads during a run
        mf_req = 1'b1; mf_hi = 1'b1;
        @(negedge clk);
        start = 1'b1; func = 6'h19; opnd_a = 32'h0001_0000; opnd_b = 32'h0001_0000;
        @(negedge clk);
        func = 6'h13; opnd_a = 32'hDEAD_BEEF;            // ignored while busy
        @(negedge clk);
        start = 1'b0;
        chk(mf_stall == 1'b1, "R10 stall while busy", {63'b0, mf_stall}, 64'h1);
        while (busy) @(negedge clk);
        chk(hi_out == 32'h1 && lo_out == 32'h0, "R9 start ignored while busy",
            {hi_out, lo_out}, {32'h1, 32'h0});
        mf_hi = 1'b0;
        @(negedge clk);
        chk(mf_stall == 1'b0 && mf_data == 32'h0, "R10 read lo idle",
            {31'b0, mf_stall, mf_data}, 64'h0);
        mf_req = 1'b0;

        // R9: move-from and unknown codes on start are ignored
        hold_hi = hi_out; hold_lo = lo_out;
        run_op(6'h10, 32'h5555_5555, 32'h3, 0);
        run_op(6'h12, 32'h6666_6666, 32'h3, 0);
        run_op(6'h2A, 32'h7777_7777, 32'h3, 0);
        chk(hi_out == hold_hi && lo_out == hold_lo, "R9 unknown code",
            {hi_out, lo_out}, {hold_hi, hold_lo});

        // Corner and random sweeps against the model
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                for (int f = 0; f < 4; f++) begin
                    bit [5:0] fn;
                    fn = 6'h18 + 6'(f);
                    run_op(fn, CORNER[i], CORNER[j],
                           ((f >= 2) && CORNER[j] == 0) ? 0 : W + 1);
                end
            end
        end
        for (int k = 0; k < 60; k++) begin
            bit [31:0] a, b;
            bit [5:0]  fn;
            a  = $urandom();
            b  = (k % 3 == 0) ? ($urandom() & 32'hFF) : $urandom();
            fn = 6'h18 + 6'(k % 4);
            run_op(fn, a, b, ((fn >= 6'h1A) && b == 0) ? 0 : W + 1);
        end

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule